// File: doc/BRIEF.md
# AHB Data-Phase Response Multiplexer

This block sits on the subordinate side of a single-manager AHB-Lite fabric and chooses which subordinate's response reaches the shared bus. The address decoder outside it produces a one-hot region vector from the address-phase address. The block registers that vector into a data-phase select. The data-phase select then steers the chosen subordinate's HREADYOUT, HRDATA and HRESP onto the bus HREADY, HRDATA and HRESP.

One select bit stands for a catch-all "none" region. It covers accesses that hit no mapped range. This region always completes the transfer at once with zero data and an OKAY response, so an unmapped access cannot hang the bus.

The select register loads only while the bus HREADY is high. A subordinate that stretches its data phase with wait states therefore keeps control of the bus response until it finishes, even if the manager has already placed the next address phase on the bus. The return path is a flat AND-OR over the one-hot select and has no priority logic.

Top module: `ahb_resp_mux`

## Requirements
- R1: The first cycle after reset is released, the data-phase select points at the none region only. From then until the next load, the bus shows HREADY=1, HRDATA=0 and HRESP=0.
- R2: Select bit 0 is the none region. Select bit i+1 (for i from 0 to NSUB-1) is subordinate i, whose inputs are sub_ready[i], sub_rdata[i*DW +: DW] and sub_resp[i]. With the default NSUB=10, the vector is 11 bits wide.
- R3: On a rising HCLK edge where the bus HREADY is high, the data-phase select takes the value of sel_addr.
- R4: On a rising HCLK edge where the bus HREADY is low, the data-phase select keeps its value. A new sel_addr presented during a wait state has no effect on HREADY, HRDATA or HRESP until the stalled transfer completes.
- R5: The bus HREADY equals sub_ready of the selected subordinate. When the none region is selected, HREADY is 1.
- R6: The bus HRDATA equals the read data of the selected subordinate. When the none region is selected, HRDATA is all zeros.
- R7: The bus HRESP equals sub_resp of the selected subordinate, where 1 means ERROR and 0 means OKAY. When the none region is selected, HRESP is 0.
- R8: Given a one-hot sel_addr, the data-phase select is one-hot at all times after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Synchronous reset, active low |
| sel_addr | input | NSUB+1 | One-hot address-phase region select; bit 0 is the none region |
| sub_ready | input | NSUB | HREADYOUT of each subordinate |
| sub_rdata | input | NSUB*DW | Packed read data of all subordinates; subordinate i occupies bits i*DW +: DW |
| sub_resp | input | NSUB | HRESP of each subordinate (1 = ERROR) |
| hready | output | 1 | Bus HREADY |
| hrdata | output | DW | Bus HRDATA |
| hresp | output | 1 | Bus HRESP |

## Verification
The hardest case to reach is a wait state that overlaps a fresh address phase. One subordinate holds its ready low while sel_addr already names a different region. The returned data and ready must still belong to the stalled subordinate, and the handover must happen only on the edge after its ready rises. The bench builds this directly: it selects a subordinate and pulls that subordinate's ready low. It then presents another region, either mapped or the none region, for three cycles, checking every cycle. Finally it releases the stall and checks that the new region takes over one edge later. A sweep over every region and every ready and response level of the selected subordinate covers the steering itself. In that sweep, the read data of all subordinates changes every step, so a wrong or stale selection shows up.

// File: rtl/ahb_resp_mux.sv
module ahb_resp_mux #(
  parameter int NSUB = 10,
  parameter int DW   = 32
) (
  input  logic               hclk,
  input  logic               hresetn,
  input  logic [NSUB:0]      sel_addr,
  input  logic [NSUB-1:0]    sub_ready,
  input  logic [NSUB*DW-1:0] sub_rdata,
  input  logic [NSUB-1:0]    sub_resp,
  output logic               hready,
  output logic [DW-1:0]      hrdata,
  output logic               hresp
);
  localparam int NSEL = NSUB + 1;
  localparam logic [NSEL-1:0] SEL_NONE = NSEL'(1);

  logic [NSEL-1:0] sel_q;

  always_ff @(posedge hclk)
    if (!hresetn)    sel_q <= SEL_NONE;
    else if (hready) sel_q <= sel_addr;

  logic [NSUB-1:0]   pick;
  logic [NSUB*DW-1:0] masked;
  assign pick = sel_q[NSEL-1:1];

  genvar g;
  generate
    for (g = 0; g < NSUB; g++) begin : g_lane
      assign masked[g*DW +: DW] = {DW{pick[g]}} & sub_rdata[g*DW +: DW];
    end
  endgenerate

  always_comb begin
    hrdata = '0;
    for (int i = 0; i < NSUB; i++) hrdata = hrdata | masked[i*DW +: DW];
  end

  assign hready = sel_q[0] | |(pick & sub_ready);
  assign hresp  = |(pick & sub_resp);
endmodule

// File: rtl/ahb_resp_mux_chk.sv
module ahb_resp_mux_chk #(
  parameter int NSUB = 10,
  parameter int DW   = 32
) (
  input logic            hclk,
  input logic            hresetn,
  input logic [NSUB:0]   sel_addr,
  input logic [NSUB:0]   sel_q,
  input logic            hready,
  input logic [DW-1:0]   hrdata,
  input logic            hresp
);
  assert_reset_none_R1: assert property (@(posedge hclk) disable iff (!hresetn)
    $rose(hresetn) |-> (sel_q == (NSUB+1)'(1)));

  assert_load_R3: assert property (@(posedge hclk) disable iff (!hresetn)
    hready |=> (sel_q == $past(sel_addr)));

  assert_hold_R4: assert property (@(posedge hclk) disable iff (!hresetn)
    !hready |=> $stable(sel_q));

  assert_none_ready_R5: assert property (@(posedge hclk) disable iff (!hresetn)
    !hready |-> !sel_q[0]);

  assert_none_data_R6: assert property (@(posedge hclk) disable iff (!hresetn)
    sel_q[0] |-> (hrdata == '0));

  assert_none_okay_R7: assert property (@(posedge hclk) disable iff (!hresetn)
    sel_q[0] |-> !hresp);

  assert_onehot_R8: assert property (@(posedge hclk) disable iff (!hresetn)
    $onehot(sel_addr) |=> $onehot(sel_q));
endmodule

bind ahb_resp_mux ahb_resp_mux_chk #(.NSUB(NSUB), .DW(DW)) u_chk (
  .hclk(hclk), .hresetn(hresetn), .sel_addr(sel_addr), .sel_q(sel_q),
  .hready(hready), .hrdata(hrdata), .hresp(hresp)
);

// File: tb/tb_ahb_resp_mux.sv
module tb_ahb_resp_mux;
  localparam int NSUB = 10;
  localparam int DW   = 32;

  logic               hclk = 1'b0;
  logic               hresetn = 1'b0;
  logic [NSUB:0]      sel_addr = (NSUB+1)'(1);
  logic [NSUB-1:0]    sub_ready = '1;
  logic [NSUB*DW-1:0] sub_rdata;
  logic [NSUB-1:0]    sub_resp = '0;
  logic               hready;
  logic [DW-1:0]      hrdata;
  logic               hresp;
  logic [7:0]         salt = 8'd0;
  int                 n_run = 0;
  int                 n_fail = 0;
  bit                 done = 1'b0;

  always #10 hclk = ~hclk;

  ahb_resp_mux #(.NSUB(NSUB), .DW(DW)) dut (
    .hclk(hclk), .hresetn(hresetn), .sel_addr(sel_addr), .sub_ready(sub_ready),
    .sub_rdata(sub_rdata), .sub_resp(sub_resp),
    .hready(hready), .hrdata(hrdata), .hresp(hresp)
  );

  function automatic logic [DW-1:0] pat(int i, logic [7:0] s);
    return {8'hC0 + s, 8'(i), 16'h5A00 + 16'(i)};
  endfunction

  always_comb
    for (int i = 0; i < NSUB; i++) sub_rdata[i*DW +: DW] = pat(i, salt);

  function automatic logic [NSUB:0] oh(int r);
    return (NSUB+1)'(1) << r;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge hclk);
    #1;
    salt = salt + 8'd1;
    #1;
  endtask

  function automatic logic [DW-1:0] exp_data(int r);
    return (r == 0) ? '0 : pat(r - 1, salt);
  endfunction

  task automatic check_region(string tag, int r);
    chk({tag, " R5 hready"}, DW'(hready), DW'((r == 0) ? 1'b1 : sub_ready[r-1]));
    chk({tag, " R6 hrdata"}, hrdata, exp_data(r));
    chk({tag, " R7 hresp"},  DW'(hresp),  DW'((r == 0) ? 1'b0 : sub_resp[r-1]));
  endtask

  task automatic stall_then_switch(int a, int b);
    sel_addr = oh(a); sub_ready = '1; sub_resp = '0;
    step();
    check_region("load R3", a);
    sel_addr = oh(b);
    sub_ready[a-1] = 1'b0;
    #1;
    chk("stall R4 hready", DW'(hready), '0);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("stall R4 hready", DW'(hready), '0);
      chk("stall R4 hrdata", hrdata, pat(a - 1, salt));
    end
    sub_ready[a-1] = 1'b1;
    #1;
    chk("release R5 hready", DW'(hready), 1);
    chk("release R4 hrdata", hrdata, pat(a - 1, salt));
    step();
    check_region("switch R3", b);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge hclk);
    #1;
    sel_addr = oh(5);
    hresetn = 1'b1;
    #1;
    // R1 R8: reset leaves the none region selected
    chk("reset R1 hready", DW'(hready), 1);
    chk("reset R1 hrdata", hrdata, '0);
    chk("reset R1 hresp",  DW'(hresp), 0);

    // R2 R3 R5 R6 R7: sweep every region and every ready/resp level
    for (int r = 0; r <= NSUB; r++) begin
      sel_addr = oh(r); sub_ready = '1; sub_resp = '0;
      step();
      check_region("sweep R2", r);
      for (int v = 0; v < 4; v++) begin
        sub_ready = '1; sub_resp = '0;
        if (r != 0) begin
          sub_ready[r-1] = v[0];
          sub_resp[r-1]  = v[1];
        end
        for (int j = 0; j < NSUB; j++) if (j != r - 1) sub_resp[j] = v[0];
        #1;
        check_region("levels R5", r);
      end
      sub_ready = '1; sub_resp = '0;
      #1;
    end

    // R4: wait state overlapping a new address phase
    stall_then_switch(4, 8);
    stall_then_switch(10, 1);
    stall_then_switch(2, 0);
    stall_then_switch(7, 3);

    // R1: reset in the middle of a stall returns to none
    sel_addr = oh(6); sub_ready = '1;
    step();
    sub_ready[5] = 1'b0;
    hresetn = 1'b0;
    step();
    hresetn = 1'b1;
    sel_addr = oh(6);
    #1;
    chk("re-reset R1 hready", DW'(hready), 1);
    chk("re-reset R1 hrdata", hrdata, '0);
    sub_ready = '1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule